// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous burst memory. It holds a registered base address and a two-bit beat counter that steers the two lowest address bits. A burst starts when either of two load strobes captures an external address. One strobe belongs to the processor side and is qualified by a chip-select. The other belongs to the controller side and loads on its own. Each later beat is produced inside the block and moves forward only while the advance input is high.

An order-select input sets how the low two bits run through the four beats. In linear order they count upward from the captured value and wrap at four. In interleaved order they are the captured value XORed with the beat count. The burst is optional: a fresh address may be loaded on every cycle with no wait state.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `curAddr` is zero.
- R2: When `ctrlStrobe` is high at a clock edge, `extAddr` is captured whatever the value of `chipSel`. After that edge `curAddr` equals the captured address, with the beat count at zero.
- R3: A high `procStrobe` captures `extAddr` only when `chipSel` is 1 at the same edge. With `chipSel` at 0 it has no effect on `curAddr`.
- R4: An edge with `advance` high and no load adds one to the beat count, modulo 4. After the fourth beat the address returns to that of the first beat.
- R5: With `orderSel` = 0 (linear), the low two bits of `curAddr` are (captured low bits + beat count) mod 4.
- R6: With `orderSel` = 1 (interleaved), the low two bits of `curAddr` are the captured low bits XOR the beat count. From a start of 1 the order is 1, 0, 3, 2.
- R7: Advancing never changes bits above bit 1 of `curAddr`, including when the low bits wrap.
- R8: When a load and `advance` come at the same edge, the load wins and the beat count becomes zero.
- R9: An edge with no load and no advance leaves the base address and the beat count unchanged.
- R10: Loads on consecutive cycles each take effect, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| procStrobe | input | 1 | Processor-side load strobe, qualified by chipSel |
| ctrlStrobe | input | 1 | Controller-side load strobe, unqualified |
| chipSel | input | 1 | Chip-select that gates procStrobe |
| advance | input | 1 | Step to the next beat of the burst |
| orderSel | input | 1 | 0 = linear order, 1 = interleaved order |
| extAddr | input | ADDR_W | External address captured on a load |
| curAddr | output | ADDR_W | Current access address |

## Verification
A wrong beat count shows on the low two bits of `curAddr` one edge after the advance that caused it. The pattern tells the two orders apart: a linear step that lands on an interleaved value marks a bad order decode. A carry leaking out of the counter shows at once as a change in the upper bits. A load that is missed or wrongly gated leaves the old address on the port in the very next cycle. The stimulus runs both orders from non-zero start values so that these faults are exposed.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic load;   // capture external address, clear beat count
    logic step;   // move to next beat
  } ctlStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        procStrobe,
  input  logic        ctrlStrobe,
  input  logic        chipSel,
  input  logic        advance,
  output ctlStrobes_t strobes
);
  logic procLoad;

  always_comb begin
    procLoad      = procStrobe & chipSel;
    strobes.load  = procLoad | ctrlStrobe;
    strobes.step  = advance & ~strobes.load;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.load, strobes.step})); // R8

  AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (procStrobe && !chipSel && !ctrlStrobe) |-> !strobes.load); // R3

  AST_CTRL_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlStrobe |-> strobes.load); // R2
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (strobes.load) begin
      baseAddr <= extAddr;
      beatCnt  <= '0;
    end else if (strobes.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    if (orderSel) lowBits = baseAddr[BEAT_W-1:0] ^ beatCnt;
    else          lowBits = baseAddr[BEAT_W-1:0] + beatCnt;
    curAddr = {baseAddr[ADDR_W-1:BEAT_W], lowBits};
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (baseAddr == $past(extAddr) && beatCnt == '0)); // R2

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.step |=> beatCnt == BEAT_W'($past(beatCnt) + 1'b1)); // R4

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.step |=> $stable(curAddr[ADDR_W-1:BEAT_W])); // R7

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.load && !strobes.step) |=> ($stable(baseAddr) && $stable(beatCnt))); // R9

  AST_UPPER_WIDTH: assert property (@(posedge clk)
    UPPER_W > 0); // structural sanity for R7
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              chipSel,
  input  logic              advance,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);
  ctlStrobes_t strobes;

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .chipSel    (chipSel),
    .advance    (advance),
    .strobes    (strobes)
  );

  burst_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .orderSel (orderSel),
    .extAddr  (extAddr),
    .curAddr  (curAddr)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    $past(!rst_n) |-> curAddr == '0); // R1
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int NVEC = 16;

  typedef struct packed {
    logic          ps;
    logic          cs;
    logic          ce;
    logic          adv;
    logic          ord;
    logic [AW-1:0] ext;
    logic [AW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  // {procStrobe, ctrlStrobe, chipSel, advance, orderSel, extAddr, expected curAddr, req}
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,18'h00105,18'h00105,4'd2},  // R2 ctrl load, no chipSel
    '{1'b0,1'b0,1'b0,1'b1,1'b0,18'h00000,18'h00106,4'd5},  // R5 linear beat1
    '{1'b0,1'b0,1'b0,1'b1,1'b0,18'h00000,18'h00107,4'd5},  // R5 linear beat2
    '{1'b0,1'b0,1'b0,1'b1,1'b0,18'h00000,18'h00104,4'd7},  // R7 low wrap, upper kept
    '{1'b0,1'b0,1'b0,1'b1,1'b0,18'h00000,18'h00105,4'd4},  // R4 back to first beat
    '{1'b1,1'b0,1'b1,1'b0,1'b1,18'h2A3C1,18'h2A3C1,4'd3},  // R3 proc load with chipSel
    '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h00000,18'h2A3C0,4'd6},  // R6 interleaved 1->0
    '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h00000,18'h2A3C3,4'd6},  // R6 ->3
    '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h00000,18'h2A3C2,4'd6},  // R6 ->2
    '{1'b0,1'b0,1'b0,1'b0,1'b1,18'h3FFFF,18'h2A3C2,4'd9},  // R9 hold
    '{1'b1,1'b0,1'b0,1'b0,1'b1,18'h11111,18'h2A3C2,4'd3},  // R3 proc ignored without chipSel
    '{1'b0,1'b1,1'b0,1'b1,1'b1,18'h3FFF2,18'h3FFF2,4'd8},  // R8 load beats advance
    '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h00000,18'h3FFF3,4'd6},  // R6 2^1=3
    '{1'b0,1'b0,1'b0,1'b1,1'b0,18'h00000,18'h3FFF0,4'd7},  // R7 linear 2+2 no carry
    '{1'b0,1'b1,1'b0,1'b0,1'b0,18'h00003,18'h00003,4'd10}, // R10 back-to-back load
    '{1'b1,1'b0,1'b1,1'b0,1'b0,18'h00007,18'h00007,4'd10}  // R10 next cycle load
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          procStrobe, ctrlStrobe, chipSel, advance, orderSel;
  logic [AW-1:0] extAddr;
  logic [AW-1:0] curAddr;
  int            nApplied = 0;
  int            nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .chipSel(chipSel), .advance(advance), .orderSel(orderSel),
    .extAddr(extAddr), .curAddr(curAddr)
  );

  task automatic check(input logic [AW-1:0] expV, input int req);
    nApplied++;
    if (curAddr !== expV) begin
      nFail++;
      $display("FAIL R%0d: curAddr=%h expected=%h", req, curAddr, expV);
    end
  endtask

  task automatic idle();
    procStrobe = 0; ctrlStrobe = 0; chipSel = 0; advance = 0; extAddr = '0;
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    nFail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
    $finish;
  end

  initial begin
    idle(); orderSel = 1'b1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 check('0, 1); // R1 during reset
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check('0, 1); // R1 first cycle after reset

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      procStrobe = VECS[i].ps; ctrlStrobe = VECS[i].cs; chipSel = VECS[i].ce;
      advance = VECS[i].adv; orderSel = VECS[i].ord; extAddr = VECS[i].ext;
      @(posedge clk); #1;
      check(VECS[i].exp, int'(VECS[i].req));
    end

    // R1: reset in mid-burst clears address
    @(negedge clk); idle(); orderSel = 1'b0;
    ctrlStrobe = 1'b1; extAddr = 18'h15555;
    @(posedge clk); #1 check(18'h15555, 2);
    @(negedge clk); idle(); advance = 1'b1;
    @(posedge clk); #1 check(18'h15556, 5);
    @(negedge clk); idle(); rst_n = 1'b0;
    @(posedge clk); #1 check('0, 1);
    @(negedge clk); rst_n = 1'b1; advance = 1'b1;
    @(posedge clk); #1 check(18'h00001, 4); // R4 step from zeroed state

    // R6 interleaved from start 0: 0,1,2,3 then wrap (R4)
    @(negedge clk); idle(); orderSel = 1'b1; ctrlStrobe = 1'b1; extAddr = 18'h20000;
    @(posedge clk); #1 check(18'h20000, 6);
    for (int b = 1; b <= 4; b++) begin
      @(negedge clk); idle(); advance = 1'b1;
      @(posedge clk); #1 check(18'h20000 | AW'(b % 4), (b == 4) ? 4 : 6);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
    $finish;
  end
endmodule